// File: doc/BRIEF.md
# Core-to-host-module I/O access bridge

This block lets an embedded core reach the host-facing modules of a chip (a keyboard controller and a configuration space behind an index/data pair) by generating host-style I/O cycles itself. The core programs a small register file: an I/O offset, a data byte, a control/status register, a per-module host lockout mask, a per-module core-access enable mask and a timeout limit. Writing the data byte launches a write cycle; setting the read bit in the control register launches a read cycle whose result lands in the data byte.

Each cycle travels to the target over a valid/ready bus that carries a one-hot module select, the offset, the write byte and a direction flag, all held steady until the target answers. The lockout mask goes straight to the host-side logic so host accesses to a locked module stall while the core uses it. A configuration read is done in two cycles: write the index at the even offset, then read at the odd offset.

Faults are caught rather than hung on: a start while a cycle is active, a cycle with no module enabled and a target that never answers all complete cleanly and leave a sticky flag.

Top module: `core_hio_bridge`

## Requirements
- R1: After reset every register reads 0 (offset 0 I/O address, 1 data, 2 control, 3 lock, 4 enable, 5 timeout limit), no cycle is presented and no module is locked.
- R2: A core write to the data register (offset 1) while idle starts a write cycle with the direction flag high, the I/O address and the written byte; control bit 1 reads 1 from the clock after the write until the target accepts.
- R3: Writing control (offset 2) with bit 0 set while idle starts a read cycle; bit 0 reads 1 until it ends, after which the data register holds the byte returned by the target.
- R4: A cycle goes to the keyboard module (select bit 0) when enable bit 0 is set, else to the configuration module (select bit 1); the offset, including bit 0 choosing index (0) or data (1), is passed unchanged, so an index write at an even offset followed by a read at the next odd offset returns the stored configuration byte.
- R5: The lock register bits (bit 0 keyboard, bit 1 configuration) drive the host lockout outputs of the same bit positions.
- R6: A start with both enable bits clear presents no cycle, never sets a busy bit, loads 0xFF into the data register on a read, and sets the error flag (control bit 2).
- R7: A start issued while either busy bit is set is ignored (the active cycle and the data register are unchanged) and sets the error flag; control bits 2 and 3 are cleared only by writing 1 to them.
- R8: With limit L, a cycle not accepted within L+1 clocks of valid is abandoned: busy clears, a read loads 0xFF, and the timeout flag (control bit 3) sets; acceptance within L+1 clocks leaves the flag clear.
- R9: While valid is high and ready low, valid, select, offset, write byte and direction stay unchanged on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Core register write strobe |
| reg_addr | input | 3 | Core register offset |
| reg_wdata | input | 8 | Core register write data |
| reg_rdata | output | 8 | Core register read data (combinational) |
| tgt_valid | output | 1 | Cycle presented to a target |
| tgt_ready | input | 1 | Target accepts the cycle |
| tgt_sel | output | 2 | One-hot target module select |
| tgt_addr | output | 8 | I/O offset of the cycle |
| tgt_wdata | output | 8 | Write byte |
| tgt_write | output | 1 | 1 = write cycle, 0 = read cycle |
| tgt_rdata | input | 8 | Read byte returned with ready |
| host_lock | output | 2 | Per-module host lockout |

## Verification
The bench sweeps target latency against the timeout limit so the boundary where acceptance in the last allowed clock must still succeed is hit; an off-by-one in the counter would flag a timeout one latency early or late. It fires second starts into an active cycle, where a design that honoured them would overwrite the byte seen by the target or corrupt the data register. It runs cycles with nothing enabled, where a wrong design would hang busy or drive a cycle, and it replays the configuration index/data sequence over many indices, which catches a bridge that mangles offset bit 0 or routes to the wrong module.

// File: rtl/core_hio_pkg.sv
package core_hio_pkg;
  localparam int DW   = 8;
  localparam int AW   = 8;
  localparam int NMOD = 2;
  localparam int RAW  = 3;

  localparam logic [RAW-1:0] OFS_IOADDR = 3'd0;
  localparam logic [RAW-1:0] OFS_DATA   = 3'd1;
  localparam logic [RAW-1:0] OFS_CTRL   = 3'd2;
  localparam logic [RAW-1:0] OFS_LOCK   = 3'd3;
  localparam logic [RAW-1:0] OFS_AEN    = 3'd4;
  localparam logic [RAW-1:0] OFS_TLIM   = 3'd5;

  localparam int CB_RD  = 0;
  localparam int CB_WR  = 1;
  localparam int CB_ERR = 2;
  localparam int CB_TMO = 3;

  typedef enum logic {ENG_IDLE, ENG_BUSY} eng_state_e;
endpackage

// File: rtl/core_hio_engine.sv
module core_hio_engine
  import core_hio_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_wr,
  input  logic            req_rd,
  input  logic [AW-1:0]   io_addr,
  input  logic [DW-1:0]   wr_byte,
  input  logic [NMOD-1:0] aen,
  input  logic [CW-1:0]   tlim,
  output logic            busy_rd,
  output logic            busy_wr,
  output logic            load_data,
  output logic [DW-1:0]   load_byte,
  output logic            err_set,
  output logic            tmo_set,
  output logic            tgt_valid,
  input  logic            tgt_ready,
  output logic [NMOD-1:0] tgt_sel,
  output logic [AW-1:0]   tgt_addr,
  output logic [DW-1:0]   tgt_wdata,
  output logic            tgt_write,
  input  logic [DW-1:0]   tgt_rdata
);
  localparam logic [DW-1:0] FILL = {DW{1'b1}};

  eng_state_e      st_q, st_d;
  logic            isrd_q, isrd_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic [DW-1:0]   wdat_q, wdat_d;
  logic [NMOD-1:0] sel_q, sel_d;
  logic [CW-1:0]   cnt_q, cnt_d, lim_q, lim_d;
  logic [NMOD-1:0] pick;
  logic            req;

  assign req = req_wr | req_rd;

  // lowest enabled module wins
  always_comb begin
    pick = '0;
    for (int i = NMOD - 1; i >= 0; i--) begin
      if (aen[i]) pick = NMOD'(1) << i;
    end
  end

  always_comb begin
    st_d = st_q; isrd_d = isrd_q; addr_d = addr_q; wdat_d = wdat_q;
    sel_d = sel_q; cnt_d = cnt_q; lim_d = lim_q;
    load_data = 1'b0; load_byte = FILL; err_set = 1'b0; tmo_set = 1'b0;
    if (st_q == ENG_IDLE) begin
      if (req) begin
        if (aen == '0) begin
          err_set   = 1'b1;
          load_data = req_rd;
        end else begin
          st_d   = ENG_BUSY;
          isrd_d = req_rd;
          addr_d = io_addr;
          wdat_d = wr_byte;
          sel_d  = pick;
          cnt_d  = '0;
          lim_d  = tlim;
        end
      end
    end else begin
      err_set = req;
      if (tgt_ready) begin
        st_d      = ENG_IDLE;
        load_data = isrd_q;
        load_byte = tgt_rdata;
      end else if (cnt_q >= lim_q) begin
        st_d      = ENG_IDLE;
        load_data = isrd_q;
        tmo_set   = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ENG_IDLE; isrd_q <= 1'b0; addr_q <= '0; wdat_q <= '0;
      sel_q <= '0; cnt_q <= '0; lim_q <= '0;
    end else begin
      st_q <= st_d; isrd_q <= isrd_d; addr_q <= addr_d; wdat_q <= wdat_d;
      sel_q <= sel_d; cnt_q <= cnt_d; lim_q <= lim_d;
    end
  end

  assign tgt_valid = (st_q == ENG_BUSY);
  assign tgt_sel   = tgt_valid ? sel_q : '0;
  assign tgt_addr  = addr_q;
  assign tgt_wdata = wdat_q;
  assign tgt_write = ~isrd_q;
  assign busy_rd   = tgt_valid & isrd_q;
  assign busy_wr   = tgt_valid & ~isrd_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_valid && !tgt_ready && !tmo_set) |=> (tgt_valid && $stable(tgt_sel) && $stable(tgt_addr)
      && $stable(tgt_wdata) && $stable(tgt_write))); // R9
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid |-> ($countones(tgt_sel) == 1)); // R4
  AST_NOEN_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tgt_valid && req && aen == '0) |=> !tgt_valid); // R6
  AST_ACCEPT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_valid && tgt_ready) |=> !tgt_valid); // R2
endmodule

// File: rtl/core_hio_regs.sv
module core_hio_regs
  import core_hio_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [RAW-1:0]  reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            busy_rd,
  input  logic            busy_wr,
  input  logic            load_data,
  input  logic [DW-1:0]   load_byte,
  input  logic            err_set,
  input  logic            tmo_set,
  output logic            req_wr,
  output logic            req_rd,
  output logic [AW-1:0]   io_addr,
  output logic [NMOD-1:0] lock,
  output logic [NMOD-1:0] aen,
  output logic [CW-1:0]   tlim
);
  logic [AW-1:0]   ioa_q, ioa_d;
  logic [DW-1:0]   dat_q, dat_d;
  logic [NMOD-1:0] lck_q, lck_d, aen_q, aen_d;
  logic [CW-1:0]   tl_q, tl_d;
  logic            err_q, err_d, tmo_q, tmo_d;
  logic            busy, ctrl_we;

  assign busy    = busy_rd | busy_wr;
  assign ctrl_we = reg_we && (reg_addr == OFS_CTRL);
  assign req_wr  = reg_we && (reg_addr == OFS_DATA);
  assign req_rd  = ctrl_we && reg_wdata[CB_RD];

  always_comb begin
    ioa_d = ioa_q; dat_d = dat_q; lck_d = lck_q; aen_d = aen_q; tl_d = tl_q;
    err_d = err_q; tmo_d = tmo_q;
    if (reg_we) begin
      case (reg_addr)
        OFS_IOADDR: ioa_d = reg_wdata[AW-1:0];
        OFS_LOCK:   lck_d = reg_wdata[NMOD-1:0];
        OFS_AEN:    aen_d = reg_wdata[NMOD-1:0];
        OFS_TLIM:   tl_d  = reg_wdata[CW-1:0];
        default: ;
      endcase
    end
    if (req_wr && !busy) dat_d = reg_wdata;
    if (load_data)       dat_d = load_byte;
    if (ctrl_we && reg_wdata[CB_ERR]) err_d = 1'b0;
    if (ctrl_we && reg_wdata[CB_TMO]) tmo_d = 1'b0;
    if (err_set) err_d = 1'b1;
    if (tmo_set) tmo_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ioa_q <= '0; dat_q <= '0; lck_q <= '0; aen_q <= '0; tl_q <= '0;
      err_q <= 1'b0; tmo_q <= 1'b0;
    end else begin
      ioa_q <= ioa_d; dat_q <= dat_d; lck_q <= lck_d; aen_q <= aen_d; tl_q <= tl_d;
      err_q <= err_d; tmo_q <= tmo_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_IOADDR: reg_rdata = DW'(ioa_q);
      OFS_DATA:   reg_rdata = dat_q;
      OFS_CTRL: begin
        reg_rdata[CB_RD]  = busy_rd;
        reg_rdata[CB_WR]  = busy_wr;
        reg_rdata[CB_ERR] = err_q;
        reg_rdata[CB_TMO] = tmo_q;
      end
      OFS_LOCK:   reg_rdata = DW'(lck_q);
      OFS_AEN:    reg_rdata = DW'(aen_q);
      OFS_TLIM:   reg_rdata = DW'(tl_q);
      default: ;
    endcase
  end

  assign io_addr = ioa_q;
  assign lock    = lck_q;
  assign aen     = aen_q;
  assign tlim    = tl_q;

  AST_BUSY_REQ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (req_wr || req_rd)) |=> err_q); // R7
  AST_BUSY_DATA_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_wr && !load_data) |=> $stable(dat_q)); // R7
  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_q && !(ctrl_we && reg_wdata[CB_TMO])) |=> tmo_q); // R8
endmodule

// File: rtl/core_hio_bridge.sv
module core_hio_bridge
  import core_hio_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RAW-1:0]    reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              tgt_valid,
  input  logic              tgt_ready,
  output logic [NMOD-1:0]   tgt_sel,
  output logic [AW-1:0]     tgt_addr,
  output logic [DW-1:0]     tgt_wdata,
  output logic              tgt_write,
  input  logic [DW-1:0]     tgt_rdata,
  output logic [NMOD-1:0]   host_lock
);
  logic [1:0]      rsync_q;
  logic            rst_s_n;
  logic            req_wr, req_rd, busy_rd, busy_wr, load_data, err_set, tmo_set;
  logic [DW-1:0]   load_byte;
  logic [AW-1:0]   io_addr;
  logic [NMOD-1:0] aen;
  logic [CW-1:0]   tlim;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  core_hio_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy_rd(busy_rd),
    .busy_wr(busy_wr), .load_data(load_data), .load_byte(load_byte),
    .err_set(err_set), .tmo_set(tmo_set), .req_wr(req_wr), .req_rd(req_rd),
    .io_addr(io_addr), .lock(host_lock), .aen(aen), .tlim(tlim)
  );

  core_hio_engine #(.CW(CW)) u_eng (
    .clk(clk), .rst_n(rst_s_n), .req_wr(req_wr), .req_rd(req_rd),
    .io_addr(io_addr), .wr_byte(reg_wdata), .aen(aen), .tlim(tlim),
    .busy_rd(busy_rd), .busy_wr(busy_wr), .load_data(load_data),
    .load_byte(load_byte), .err_set(err_set), .tmo_set(tmo_set),
    .tgt_valid(tgt_valid), .tgt_ready(tgt_ready), .tgt_sel(tgt_sel),
    .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata), .tgt_write(tgt_write),
    .tgt_rdata(tgt_rdata)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_s_n |-> (!tgt_valid && host_lock == '0)); // R1
endmodule

// File: tb/core_hio_bridge_tb.sv
module core_hio_bridge_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tgt_valid, tgt_write;
  logic       tgt_ready = 1'b0;
  logic [1:0] tgt_sel, host_lock;
  logic [7:0] tgt_addr, tgt_wdata;
  logic [7:0] tgt_rdata = '0;

  int checks = 0, fails = 0;
  int lat = 1;
  int vcnt = 0;
  int ncycles = 0;
  logic [7:0] cfg_idx = '0;
  logic [7:0] cfg_mem [16];
  logic [1:0] last_sel = '0;
  logic [7:0] last_addr = '0, last_wdata = '0;
  int nwrites = 0;
  logic [7:0] v;

  always #10 clk = ~clk;

  core_hio_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tgt_valid(tgt_valid),
    .tgt_ready(tgt_ready), .tgt_sel(tgt_sel), .tgt_addr(tgt_addr),
    .tgt_wdata(tgt_wdata), .tgt_write(tgt_write), .tgt_rdata(tgt_rdata),
    .host_lock(host_lock)
  );

  // target model: answers after lat valid clocks (lat 0 = never)
  always @(negedge clk) begin
    if (tgt_valid) begin
      vcnt = vcnt + 1;
      if (lat != 0 && vcnt == lat) begin
        tgt_ready = 1'b1;
        if (tgt_sel == 2'b01) tgt_rdata = tgt_addr ^ 8'hA5;
        else if (tgt_addr[0]) tgt_rdata = cfg_mem[cfg_idx[3:0]];
        else tgt_rdata = cfg_idx;
        if (tgt_write) begin
          nwrites = nwrites + 1;
          last_sel = tgt_sel; last_addr = tgt_addr; last_wdata = tgt_wdata;
          if (tgt_sel == 2'b10) begin
            if (tgt_addr[0]) cfg_mem[cfg_idx[3:0]] = tgt_wdata;
            else cfg_idx = tgt_wdata;
          end
        end
      end else tgt_ready = 1'b0;
    end else begin
      vcnt = 0;
      tgt_ready = 1'b0;
    end
  end

  always @(posedge clk) begin
    ncycles = ncycles + 1;
    if (ncycles > 150000) begin
      checks = checks + 1; fails = fails + 1;
      $display("FAIL watchdog: act=%0d cycles exp<150000", ncycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] c;
    for (int i = 0; i < 64; i++) begin
      rd(3'd2, c);
      if (c[1:0] == 2'b00) break;
      @(negedge clk);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) cfg_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk(v == 8'h00, "R1 reg reset", v, 0);
    end
    chk(!tgt_valid && host_lock == 2'b00, "R1 idle outputs", {tgt_valid, host_lock}, 0);

    // R5 lock passthrough
    for (int l = 0; l < 4; l++) begin
      wr(3'd3, 8'(l));
      chk(host_lock == 2'(l), "R5 host lock", host_lock, l);
    end
    wr(3'd3, 8'h00);

    // R6 nothing enabled
    lat = 1;
    wr(3'd2, 8'h01);
    rd(3'd2, v);
    chk(v == 8'h04, "R6 ctrl after read no enable", v, 8'h04);
    chk(!tgt_valid, "R6 no cycle", tgt_valid, 0);
    rd(3'd1, v);
    chk(v == 8'hFF, "R6 data fill", v, 8'hFF);
    // R7 error clears only by writing 1
    wr(3'd2, 8'h00);
    rd(3'd2, v);
    chk(v[2] == 1'b1, "R7 err sticky on zero write", v[2], 1);
    wr(3'd2, 8'h04);
    rd(3'd2, v);
    chk(v[2] == 1'b0, "R7 err w1c", v[2], 0);
    wr(3'd1, 8'h3C);
    rd(3'd2, v);
    chk(v == 8'h04 && nwrites == 0, "R6 write no enable", v, 8'h04);
    wr(3'd2, 8'h04);

    // R2 R3 R4 keyboard sweep, keyboard has priority over config
    wr(3'd4, 8'h03);
    wr(3'd5, 8'd10);
    for (int a = 0; a < 16; a++) begin
      lat = 1 + (a % 3);
      wr(3'd0, 8'(a * 17));
      wr(3'd1, 8'(a * 7 + 3));
      rd(3'd2, v);
      if (lat > 1) chk(v[1] == 1'b1, "R2 write busy", v, 2);
      wait_idle();
      chk(last_sel == 2'b01 && last_addr == 8'(a * 17) && last_wdata == 8'(a * 7 + 3),
          "R2 R4 write cycle fields", {last_sel, last_addr, last_wdata}, {2'b01, 8'(a * 17), 8'(a * 7 + 3)});
      wr(3'd2, 8'h01);
      rd(3'd2, v);
      if (lat > 1) chk(v[0] == 1'b1, "R3 read busy", v, 1);
      wait_idle();
      rd(3'd1, v);
      chk(v == (8'(a * 17) ^ 8'hA5), "R3 read data", v, 8'(a * 17) ^ 8'hA5);
    end

    // R4 configuration index/data sequence
    wr(3'd4, 8'h02);
    lat = 2;
    for (int i = 0; i < 16; i++) begin
      wr(3'd0, 8'h2E); wr(3'd1, 8'(i)); wait_idle();
      wr(3'd0, 8'h2F); wr(3'd1, 8'(i * 13 + 1)); wait_idle();
      chk(last_sel == 2'b10, "R4 config select", last_sel, 2);
    end
    for (int i = 15; i >= 0; i--) begin
      wr(3'd0, 8'h2E); wr(3'd1, 8'(i)); wait_idle();
      wr(3'd0, 8'h2F); wr(3'd2, 8'h01); wait_idle();
      rd(3'd1, v);
      chk(v == 8'(i * 13 + 1), "R4 config readback", v, 8'(i * 13 + 1));
    end

    // R7 start while busy
    wr(3'd4, 8'h01);
    lat = 6;
    wr(3'd0, 8'h40);
    wr(3'd1, 8'h11);
    wr(3'd1, 8'h22);
    wr(3'd2, 8'h01);
    wait_idle();
    chk(last_wdata == 8'h11, "R7 second write ignored", last_wdata, 8'h11);
    rd(3'd1, v);
    chk(v == 8'h11, "R7 data kept", v, 8'h11);
    rd(3'd2, v);
    chk(v == 8'h04, "R7 err set, no cycle active", v, 8'h04);
    wr(3'd2, 8'h04);

    // R8 timeout sweep
    wr(3'd0, 8'h05);
    for (int lim = 0; lim < 4; lim++) begin
      wr(3'd5, 8'(lim));
      for (int l = 0; l < 7; l++) begin
        lat = l;
        wr(3'd2, 8'h01);
        wait_idle();
        rd(3'd2, v);
        if (l == 0 || l > lim + 1) begin
          chk(v == 8'h08, "R8 timeout flag", v, 8'h08);
          rd(3'd1, v);
          chk(v == 8'hFF, "R8 timeout fill", v, 8'hFF);
        end else begin
          chk(v == 8'h00, "R8 no timeout", v, 0);
          rd(3'd1, v);
          chk(v == 8'hA0, "R8 in-time data", v, 8'hA0);
        end
        wr(3'd2, 8'h00);
        rd(3'd2, v);
        chk(v[3] == (l == 0 || l > lim + 1), "R8 tmo sticky", v[3], (l == 0 || l > lim + 1));
        wr(3'd2, 8'h08);
        rd(3'd2, v);
        chk(v[3] == 1'b0, "R8 tmo w1c", v[3], 0);
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule